// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block reproduces the control timing of a processor core as it enters an interrupt handler. It watches a set of interrupt request lines, each with its own priority in a flat table, and picks one winner. One cycle after the winning line is sampled it raises a recognition pulse. From the next cycle it runs two things side by side. On the data side it writes an eight-word register frame just below the stack pointer. On the instruction side it reads the vector-table entry of the chosen handler.

The first handler instruction reaches the execute stage a fixed twelve cycles after the request. In that cycle a 3-bit trace status shows the entry code for one cycle only. The active priority becomes valid in that same cycle. The active exception number is already valid while the vector is being fetched. Both values hold until a handler-done input returns the block to idle. The block does not handle nesting, tail-chaining, late arrival or exception return.

Top module: `irq_entry_seq`

## Requirements
- R1: A request line sampled high at a clock edge while the block is idle makes `recog` high for exactly the one cycle that follows that edge.
- R2: In the cycle after `recog`, `push_valid` and `fetch_valid` are both high. `fetch_valid` lasts one cycle, with `fetch_addr` = `vec_base` + 4 × exception number.
- R3: The frame base is `sp_in` − 32, shown on `sp_out` from the first push cycle on. Frame slot k (0..7) is stored at base + 4k and holds word k of `frame_in` (bits 32k+31:32k). Slots 0..7 are r0, r1, r2, r3, r12, LR, PC and xPSR.
- R4: The push lasts eight consecutive cycles and writes the slots in the order 6, 7, 0, 1, 2, 3, 4, 5. This puts offset 0x18 first and 0x1C second.
- R5: `trace_stat` is 3'b000 except in the single cycle that comes 12 cycles after the request cycle, where it is 3'b001.
- R6: `act_prio` reads all ones until the entry pulse. From the entry pulse until handler-done it holds the winner's priority.
- R7: `act_num` is 0 when idle. From the recognition cycle until handler-done it holds the winning line index plus 16.
- R8: Among the lines pending at once, the one with the numerically lowest priority value wins, and a tie goes to the lowest line index.
- R9: A request that arrives while an entry or handler is in progress is held pending. It is serviced once the block is idle again.
- R10: `handler_done` in the handler state returns the block to idle with `act_prio` all ones, `act_num` 0 and `trace_stat` 3'b000. `handler_done` raised during the entry sequence has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NL | Interrupt request lines |
| irq_prio | input | NL*PW | Priority of each line, line i in bits PW*i+PW-1:PW*i |
| sp_in | input | 32 | Current stack pointer |
| vec_base | input | 32 | Vector-table base address |
| frame_in | input | 256 | Frame words for slots 0..7, slot k in bits 32k+31:32k |
| handler_done | input | 1 | Handler finished; return to idle |
| recog | output | 1 | Request recognised (one-cycle pulse) |
| sp_out | output | 32 | Stack pointer: `sp_in` before the push, frame base after it |
| push_valid | output | 1 | Data-side frame write strobe |
| push_addr | output | 32 | Frame write address |
| push_data | output | 32 | Frame write data |
| fetch_valid | output | 1 | Instruction-side vector read strobe |
| fetch_addr | output | 32 | Vector read address |
| trace_stat | output | 3 | Trace status: 000 idle, 001 handler entered |
| act_prio | output | PW | Active priority, all ones when not valid |
| act_num | output | 9 | Active exception number, 0 when idle |

## Verification
The bench checks every cycle of each entry, from recognition to the cycle after the entry pulse. A design that counted the latency from recognition would move the 3'b001 pulse by one cycle. A design that pushed the frame in ascending order would put r0 rather than PC at the first write. The bench also sends two requests in the same cycle, once with different priorities and once with a priority tie. An arbiter that compared the wrong way, or broke ties towards the higher index, would report the wrong `act_num` from the recognition cycle on. The losing line must still be serviced after handler-done. A request raised mid-sequence must wait, and a handler-done pulse during the push must be ignored. Without pending storage the late request would be lost. A design that honoured the early done would lose the entry pulse.

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int NL      = 8,
  parameter int PW      = 8,
  parameter int EXC_OFS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NL-1:0]    irq_req,
  input  logic [NL*PW-1:0] irq_prio,
  input  logic [31:0]      sp_in,
  input  logic [31:0]      vec_base,
  input  logic [255:0]     frame_in,
  input  logic             handler_done,
  output logic             recog,
  output logic [31:0]      sp_out,
  output logic             push_valid,
  output logic [31:0]      push_addr,
  output logic [31:0]      push_data,
  output logic             fetch_valid,
  output logic [31:0]      fetch_addr,
  output logic [2:0]       trace_stat,
  output logic [PW-1:0]    act_prio,
  output logic [8:0]       act_num
);

  localparam int IW        = (NL > 1) ? $clog2(NL) : 1;
  localparam int ENTRY_LAT = 12;
  localparam int SEQ_LAST  = ENTRY_LAT - 3;
  localparam int CW        = $clog2(ENTRY_LAT + 4);
  localparam int FRAME_B   = 32;

  typedef enum logic [2:0] {S_IDLE, S_RECOG, S_SEQ, S_ENTER, S_ACT} st_t;

  st_t           state;
  logic [NL-1:0] pend_q, pend_d, pend_clr;
  logic [CW-1:0] cnt_q, lat_q;
  logic [PW-1:0] prio_q, win_pri;
  logic [8:0]    num_q, win_num;
  logic [IW-1:0] win_idx;
  logic          win_any;
  logic [31:0]   base_q;
  logic [2:0]    slot;

  assign pend_d = pend_q | irq_req;

  always_comb begin
    win_any = 1'b0;
    win_idx = '0;
    win_pri = '1;
    for (int i = 0; i < NL; i++) begin
      if (pend_d[i] && (!win_any || irq_prio[PW*i +: PW] < win_pri)) begin
        win_any = 1'b1;
        win_idx = IW'(i);
        win_pri = irq_prio[PW*i +: PW];
      end
    end
  end

  assign win_num  = 9'(EXC_OFS) + 9'(win_idx);
  assign pend_clr = (state == S_IDLE && win_any) ? (NL'(1) << win_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      pend_q <= '0;
      cnt_q  <= '0;
      lat_q  <= '0;
      prio_q <= '1;
      num_q  <= '0;
      base_q <= '0;
    end else begin
      pend_q <= pend_d & ~pend_clr;
      if (state == S_IDLE) lat_q <= '0;
      else if (lat_q != '1) lat_q <= lat_q + 1'b1;
      case (state)
        S_IDLE: if (win_any) begin
          state  <= S_RECOG;
          num_q  <= win_num;
          prio_q <= win_pri;
        end
        S_RECOG: begin
          state  <= S_SEQ;
          cnt_q  <= '0;
          base_q <= sp_in - 32'(FRAME_B);
        end
        S_SEQ: begin
          if (cnt_q == CW'(SEQ_LAST)) state <= S_ENTER;
          else cnt_q <= cnt_q + 1'b1;
        end
        S_ENTER: state <= S_ACT;
        S_ACT: if (handler_done) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign slot        = (cnt_q < CW'(2)) ? 3'(cnt_q + CW'(6)) : 3'(cnt_q - CW'(2));
  assign recog       = (state == S_RECOG);
  assign sp_out      = (state == S_IDLE || state == S_RECOG) ? sp_in : base_q;
  assign push_valid  = (state == S_SEQ) && (cnt_q < CW'(8));
  assign push_addr   = base_q + {27'd0, slot, 2'b00};
  assign push_data   = frame_in[32*slot +: 32];
  assign fetch_valid = (state == S_SEQ) && (cnt_q == '0);
  assign fetch_addr  = vec_base + {21'd0, num_q, 2'b00};
  assign trace_stat  = (state == S_ENTER) ? 3'b001 : 3'b000;
  assign act_prio    = (state == S_ENTER || state == S_ACT) ? prio_q : '1;
  assign act_num     = (state == S_IDLE) ? 9'd0 : num_q;

  p_recog_to_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
    recog |=> (push_valid && fetch_valid));

  p_first_push_pc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> (push_addr == sp_out + 32'h18));

  p_trace_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_stat == 3'b000 || trace_stat == 3'b001));

  p_trace_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_stat == 3'b001) |=> (trace_stat == 3'b000));

  p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_stat == 3'b001) |-> (lat_q == CW'(ENTRY_LAT - 1)));

  p_prio_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ACT) |-> $stable(act_prio));

  p_num_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && $past(state) != S_IDLE) |-> $stable(act_num));

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ACT && handler_done) |=> (act_prio == '1 && act_num == 9'd0 && trace_stat == 3'b000));

endmodule

// File: tb/tb_irq_entry_seq.sv
`timescale 1ns/1ps
module tb_irq_entry_seq;
  localparam int NL = 8;
  localparam int PW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NL-1:0] irq_req = '0;
  logic [NL*PW-1:0] irq_prio;
  logic [31:0] sp_in = 32'h2000_0400;
  logic [31:0] vec_base = 32'h0000_1000;
  logic [255:0] frame_in;
  logic handler_done = 1'b0;
  logic recog, push_valid, fetch_valid;
  logic [31:0] sp_out, push_addr, push_data, fetch_addr;
  logic [2:0] trace_stat;
  logic [PW-1:0] act_prio;
  logic [8:0] act_num;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  irq_entry_seq #(.NL(NL), .PW(PW), .EXC_OFS(16)) dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_prio(irq_prio),
    .sp_in(sp_in), .vec_base(vec_base), .frame_in(frame_in),
    .handler_done(handler_done), .recog(recog), .sp_out(sp_out),
    .push_valid(push_valid), .push_addr(push_addr), .push_data(push_data),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .trace_stat(trace_stat),
    .act_prio(act_prio), .act_num(act_num));

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One entry; cycle 0 is the current cycle. R1 R2 R3 R4 R5 R6 R7
  task automatic run_entry(input logic [NL-1:0] mask, input int line, input logic [31:0] sp,
                           input int extra_at, input logic [NL-1:0] extra_mask, input int done_at);
    logic [8:0] num;
    logic [7:0] pri;
    num = 9'(16 + line);
    pri = irq_prio[PW*line +: PW];
    sp_in = sp;
    irq_req = mask;
    for (int k = 1; k <= 13; k++) begin
      @(negedge clk);
      chk("R1", "recog", 32'(recog), 32'(k == 1));
      chk("R5", "trace", 32'(trace_stat), (k == 12) ? 32'd1 : 32'd0);
      chk("R7", "act_num", 32'(act_num), 32'(num));
      chk("R6", "act_prio", 32'(act_prio), (k >= 12) ? 32'(pri) : 32'hFF);
      chk("R2", "fetch_valid", 32'(fetch_valid), 32'(k == 2));
      chk("R4", "push_valid", 32'(push_valid), 32'(k >= 2 && k <= 9));
      if (k == 2) begin
        chk("R2", "fetch_addr", fetch_addr, vec_base + 32'(4 * (16 + line)));
        chk("R3", "sp_out", sp_out, sp - 32'd32);
      end
      if (k >= 2 && k <= 9) begin
        int s;
        s = (k - 2 < 2) ? (k - 2 + 6) : (k - 2 - 2);
        chk("R4", "push_addr", push_addr, sp - 32'd32 + 32'(4 * s));
        chk("R3", "push_data", push_data, 32'hC0DE_0000 + 32'(s));
      end
      irq_req = (k == extra_at) ? extra_mask : '0;
      handler_done = (k == done_at);
    end
    handler_done = 1'b0;
  endtask

  task automatic finish_handler();
    handler_done = 1'b1;
    @(negedge clk);
    handler_done = 1'b0;
    chk("R10", "idle prio", 32'(act_prio), 32'hFF);
    chk("R10", "idle num", 32'(act_num), 32'd0);
    chk("R10", "idle trace", 32'(trace_stat), 32'd0);
  endtask

  task automatic t_quiet(string req);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(req, "quiet recog", 32'(recog), 32'd0);
      chk(req, "quiet push", 32'(push_valid), 32'd0);
    end
  endtask

  task automatic t_single();
    run_entry(8'b0000_0100, 2, 32'h2000_0400, 0, '0, 0);
    finish_handler();
  endtask

  task automatic t_arbitrate();  // R8 then R9: line 5 beats line 1
    run_entry(8'b0010_0010, 5, 32'h2000_0800, 0, '0, 0);
    finish_handler();
    run_entry('0, 1, 32'h2000_0800, 0, '0, 0);
    finish_handler();
  endtask

  task automatic t_tie();  // R8: lines 3 and 6 equal, 3 wins
    run_entry(8'b0100_1000, 3, 32'h2000_0C00, 0, '0, 0);
    finish_handler();
    run_entry('0, 6, 32'h2000_0C00, 0, '0, 0);
    finish_handler();
  endtask

  task automatic t_late();  // R9 late request held; R10 early done ignored
    run_entry(8'b0000_0100, 2, 32'h2000_1000, 5, 8'b0000_0001, 6);
    finish_handler();
    run_entry('0, 0, 32'h2000_1000, 0, '0, 0);
    finish_handler();
  endtask

  initial begin
    for (int i = 0; i < 8; i++) frame_in[32*i +: 32] = 32'hC0DE_0000 + 32'(i);
    irq_prio = {8'hF0, 8'h10, 8'h20, 8'h90, 8'h10, 8'h80, 8'h40, 8'h70};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5", "reset trace", 32'(trace_stat), 32'd0);
    chk("R6", "reset prio", 32'(act_prio), 32'hFF);
    chk("R7", "reset num", 32'(act_num), 32'd0);
    t_quiet("R1");
    t_single();
    t_arbitrate();
    t_tie();
    t_late();
    t_quiet("R9");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule